// File: doc/BRIEF.md
# Bridge Fault Supervisor

This block watches over a pair of motor-drive full bridges. Each bridge reports a raw high-side overcurrent flag. The die temperature and the supply voltage arrive as unsigned fixed-point readings. From these inputs the block produces two kinds of per-bridge output. The first is an active-low fault indication, which mimics an open-drain flag and carries both overcurrent and thermal status. The second is a disable line that forces that bridge's gate logic off.

An overcurrent flag counts only after it has been present for a set number of clocks, and it clears only after it has been absent for another set number. A qualified overcurrent starts a trip. The bridge keeps running for a turn-off delay, is then held off for a disable time, and finally retries. Thermal shutdown and undervoltage lockout both use hysteresis and switch off every bridge. A paralleled mode lets the first overcurrent on any bridge trip all bridges together.

Top module: `bridge_guard`

## Requirements
- R1: While reset is applied and directly after it, every fault output is high (no fault), thermal shutdown is inactive, undervoltage lockout is active, and every disable output is high.
- R2: A bridge's qualified overcurrent sets after its raw flag has been sampled high on OC_ON_DLY consecutive rising edges. Its fault output then goes low.
- R3: A qualified overcurrent clears after its raw flag has been sampled low on OC_OFF_DLY consecutive rising edges. The fault output then returns high, unless thermal shutdown is active.
- R4: A trip starts on the first edge at which the bridge is idle and its trigger is set. The trigger is the bridge's own qualified overcurrent, or in paralleled mode any bridge's. The disable output rises TRIP_DLY edges after the trip starts and stays high for DIS_TIME clocks.
- R5: If the trigger is still set on the edge that ends the disable time, a new turn-off delay begins at once. The disable output drops for TRIP_DLY clocks and then rises for another disable time.
- R6: A temperature reading at or above the trip level sets thermal shutdown on the next edge. Thermal shutdown drives every fault output low and every disable output high.
- R7: Thermal shutdown clears only on a reading at or below the trip level minus the hysteresis.
- R8: A supply reading counts only when its valid strobe is high. Lockout releases on a counted reading strictly above the turn-on level, and readings without the strobe change nothing.
- R9: When no lockout is active, a counted supply reading strictly below the turn-off level sets lockout, and lockout drives every disable output high.
- R10: With paralleled mode set, an overcurrent on one bridge raises the disable outputs of all bridges on the same clock.
- R11: With paralleled mode clear, a trip on one bridge leaves the other bridges' fault and disable outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_raw | input | NUM_BR | Raw high-side overcurrent flag per bridge |
| par_mode | input | 1 | Paralleled mode: any trip disables all bridges |
| temp_val | input | TEMP_W | Die temperature, unsigned, TEMP_FRAC fraction bits |
| vs_val | input | VS_W | Supply voltage, unsigned, VS_FRAC fraction bits |
| vs_vld | input | 1 | Strobe marking vs_val as a fresh reading |
| fault_n | output | NUM_BR | Active-low fault per bridge (overcurrent or thermal) |
| br_dis | output | NUM_BR | Per-bridge gate-off command |
| therm_active | output | 1 | Thermal shutdown in force |
| uvlo_active | output | 1 | Undervoltage lockout in force |

## Verification
The hardest situation to reach is an overcurrent that is still present at the exact edge where a disable period ends. The raw flag has to stay high through the turn-off delay and the whole hold time, and it must not drop long enough to clear the qualifier. Directed runs hold the flag high across that boundary and check the output on both sides of it. The random phase uses sticky flags that flip rarely, so long runs that line up with hold ends happen often. A bench-side model follows the same requirements and is compared on every clock while paralleled mode, temperature and supply all move near their thresholds.

// File: rtl/bg_pkg.sv
package bg_pkg;
  typedef enum logic [1:0] {
    TS_IDLE  = 2'd0,
    TS_DELAY = 2'd1,
    TS_HOLD  = 2'd2
  } trip_st_e;
endpackage

// File: rtl/bg_oc_qual.sv
module bg_oc_qual #(
  parameter int ON_DLY  = 25,
  parameter int OFF_DLY = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic qual
);
  localparam int MAXD = (ON_DLY > OFF_DLY) ? ON_DLY : OFF_DLY;
  localparam int CW   = $clog2(MAXD + 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(ON_DLY - 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_DLY - 1);

  logic          q_r, q_nxt;
  logic [CW-1:0] run_r, run_nxt;

  // counts consecutive samples that disagree with the current state
  always_comb begin
    q_nxt   = q_r;
    run_nxt = '0;
    if (raw != q_r) begin
      if (run_r == (q_r ? OFF_LAST : ON_LAST)) begin
        q_nxt   = raw;
        run_nxt = '0;
      end else begin
        run_nxt = run_r + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r   <= 1'b0;
      run_r <= '0;
    end else begin
      q_r   <= q_nxt;
      run_r <= run_nxt;
    end
  end

  assign qual = q_r;
endmodule

// File: rtl/bg_trip_seq.sv
module bg_trip_seq
  import bg_pkg::*;
#(
  parameter int TRIP_DLY = 4,
  parameter int DIS_TIME = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic hold
);
  localparam int MAXD = (TRIP_DLY > DIS_TIME) ? TRIP_DLY : DIS_TIME;
  localparam int CW   = $clog2(MAXD + 1);
  localparam logic [CW-1:0] DLY_LAST  = CW'(TRIP_DLY - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(DIS_TIME - 1);

  trip_st_e      st_r, st_nxt;
  logic [CW-1:0] cnt_r, cnt_nxt;
  logic          cnt_en;

  always_comb begin
    st_nxt  = st_r;
    cnt_nxt = '0;
    cnt_en  = 1'b0;
    unique case (st_r)
      TS_IDLE: begin
        if (trig) st_nxt = TS_DELAY;
      end
      TS_DELAY: begin
        if (cnt_r == DLY_LAST) st_nxt = TS_HOLD;
        else                   cnt_en = 1'b1;
      end
      TS_HOLD: begin
        if (cnt_r == HOLD_LAST) st_nxt = trig ? TS_DELAY : TS_IDLE;
        else                    cnt_en = 1'b1;
      end
      default: st_nxt = TS_IDLE;
    endcase
    if (cnt_en) cnt_nxt = cnt_r + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r  <= TS_IDLE;
      cnt_r <= '0;
    end else begin
      st_r  <= st_nxt;
      cnt_r <= cnt_nxt;
    end
  end

  assign hold = (st_r == TS_HOLD);
endmodule

// File: rtl/bg_hyst.sv
module bg_hyst #(
  parameter int W        = 10,
  parameter int SET_LVL  = 660,
  parameter int CLR_LVL  = 600,
  parameter bit SET_HIGH = 1'b1,
  parameter bit RST_VAL  = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_en,
  input  logic [W-1:0] val,
  output logic         flag
);
  localparam logic [W-1:0] SET_V = W'(SET_LVL);
  localparam logic [W-1:0] CLR_V = W'(CLR_LVL);

  logic flag_r, flag_nxt, hit_set, hit_clr;

  generate
    if (SET_HIGH) begin : g_high
      assign hit_set = (val >= SET_V);
      assign hit_clr = (val <= CLR_V);
    end else begin : g_low
      assign hit_set = (val < SET_V);
      assign hit_clr = (val > CLR_V);
    end
  endgenerate

  always_comb begin
    flag_nxt = flag_r;
    if (smp_en) begin
      if (!flag_r && hit_set)     flag_nxt = 1'b1;
      else if (flag_r && hit_clr) flag_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_r <= RST_VAL;
    else        flag_r <= flag_nxt;
  end

  assign flag = flag_r;
endmodule

// File: rtl/bridge_guard.sv
module bridge_guard #(
  parameter int NUM_BR        = 2,
  parameter int OC_ON_DLY     = 25,
  parameter int OC_OFF_DLY    = 13,
  parameter int TRIP_DLY      = 4,
  parameter int DIS_TIME      = 25000,
  parameter int TEMP_W        = 10,
  parameter int TEMP_FRAC     = 2,
  parameter int TEMP_TRIP_DEG = 165,
  parameter int TEMP_HYST_DEG = 15,
  parameter int VS_W          = 10,
  parameter int VS_FRAC       = 4,
  parameter int VS_ON_V       = 7,
  parameter int VS_OFF_V      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_BR-1:0] oc_raw,
  input  logic              par_mode,
  input  logic [TEMP_W-1:0] temp_val,
  input  logic [VS_W-1:0]   vs_val,
  input  logic              vs_vld,
  output logic [NUM_BR-1:0] fault_n,
  output logic [NUM_BR-1:0] br_dis,
  output logic              therm_active,
  output logic              uvlo_active
);
  localparam int TEMP_TRIP = TEMP_TRIP_DEG << TEMP_FRAC;
  localparam int TEMP_CLR  = (TEMP_TRIP_DEG - TEMP_HYST_DEG) << TEMP_FRAC;
  localparam int VS_ON     = VS_ON_V << VS_FRAC;
  localparam int VS_OFF    = VS_OFF_V << VS_FRAC;

  logic [NUM_BR-1:0] oc_q;
  logic [NUM_BR-1:0] trig;
  logic [NUM_BR-1:0] hold;
  logic              any_oc;

  assign any_oc = |oc_q;

  generate
    for (genvar b = 0; b < NUM_BR; b++) begin : g_br
      bg_oc_qual #(
        .ON_DLY (OC_ON_DLY),
        .OFF_DLY(OC_OFF_DLY)
      ) u_qual (
        .clk (clk),
        .rst_n(rst_n),
        .raw (oc_raw[b]),
        .qual(oc_q[b])
      );

      assign trig[b] = par_mode ? any_oc : oc_q[b];

      bg_trip_seq #(
        .TRIP_DLY(TRIP_DLY),
        .DIS_TIME(DIS_TIME)
      ) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .trig (trig[b]),
        .hold (hold[b])
      );

      assign fault_n[b] = ~(oc_q[b] | therm_active);
      assign br_dis[b]  = hold[b] | therm_active | uvlo_active;
    end
  endgenerate

  bg_hyst #(
    .W       (TEMP_W),
    .SET_LVL (TEMP_TRIP),
    .CLR_LVL (TEMP_CLR),
    .SET_HIGH(1'b1),
    .RST_VAL (1'b0)
  ) u_therm (
    .clk   (clk),
    .rst_n (rst_n),
    .smp_en(1'b1),
    .val   (temp_val),
    .flag  (therm_active)
  );

  bg_hyst #(
    .W       (VS_W),
    .SET_LVL (VS_OFF),
    .CLR_LVL (VS_ON),
    .SET_HIGH(1'b0),
    .RST_VAL (1'b1)
  ) u_uvlo (
    .clk   (clk),
    .rst_n (rst_n),
    .smp_en(vs_vld),
    .val   (vs_val),
    .flag  (uvlo_active)
  );
endmodule

// File: rtl/bridge_guard_chk.sv
module bridge_guard_chk #(
  parameter int NUM_BR    = 2,
  parameter int TEMP_W    = 10,
  parameter int VS_W      = 10,
  parameter int TEMP_TRIP = 660,
  parameter int TEMP_CLR  = 600,
  parameter int VS_OFF    = 96
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_BR-1:0] oc_raw,
  input logic [TEMP_W-1:0] temp_val,
  input logic [VS_W-1:0]   vs_val,
  input logic              vs_vld,
  input logic [NUM_BR-1:0] fault_n,
  input logic              therm_active,
  input logic              uvlo_active
);
  a_r6_therm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_val >= TEMP_W'(TEMP_TRIP)) |=> therm_active);

  a_r7_therm_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_active && temp_val > TEMP_W'(TEMP_CLR)) |=> therm_active);

  a_r8_uvlo_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_vld |=> $stable(uvlo_active));

  a_r9_uvlo_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_vld && vs_val < VS_W'(VS_OFF)) |=> uvlo_active);

  generate
    for (genvar b = 0; b < NUM_BR; b++) begin : g_chk
      a_r2_fault_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fault_n[b]) && !therm_active) |-> $past(oc_raw[b]));
    end
  endgenerate
endmodule

bind bridge_guard bridge_guard_chk #(
  .NUM_BR   (NUM_BR),
  .TEMP_W   (TEMP_W),
  .VS_W     (VS_W),
  .TEMP_TRIP(TEMP_TRIP),
  .TEMP_CLR (TEMP_CLR),
  .VS_OFF   (VS_OFF)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .oc_raw      (oc_raw),
  .temp_val    (temp_val),
  .vs_val      (vs_val),
  .vs_vld      (vs_vld),
  .fault_n     (fault_n),
  .therm_active(therm_active),
  .uvlo_active (uvlo_active)
);

// File: tb/bridge_guard_tb.sv
module bridge_guard_tb;
  localparam int NB   = 2;
  localparam int ON   = 3;
  localparam int OFF  = 2;
  localparam int TRP  = 4;
  localparam int DIS  = 20;
  localparam int TT   = 660;
  localparam int TC   = 600;
  localparam int VON  = 112;
  localparam int VOFF = 96;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NB-1:0] oc_raw;
  logic          par_mode;
  logic [9:0]    temp_val;
  logic [9:0]    vs_val;
  logic          vs_vld;
  logic [NB-1:0] fault_n;
  logic [NB-1:0] br_dis;
  logic          therm_active;
  logic          uvlo_active;

  int n_chk = 0;
  int n_err = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bridge_guard #(
    .NUM_BR(NB), .OC_ON_DLY(ON), .OC_OFF_DLY(OFF), .TRIP_DLY(TRP), .DIS_TIME(DIS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .oc_raw(oc_raw), .par_mode(par_mode),
    .temp_val(temp_val), .vs_val(vs_val), .vs_vld(vs_vld),
    .fault_n(fault_n), .br_dis(br_dis),
    .therm_active(therm_active), .uvlo_active(uvlo_active)
  );

  // reference model built from the requirements
  int mq[NB], mrun[NB], mph[NB], mrem[NB];
  bit mth, muv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin
        mq[i] = 0; mrun[i] = 0; mph[i] = 0; mrem[i] = 0;
      end
      mth = 1'b0;
      muv = 1'b1;
    end else begin
      int anyq;
      anyq = 0;
      for (int i = 0; i < NB; i++) if (mq[i] != 0) anyq = 1;
      for (int i = 0; i < NB; i++) begin
        int tg;
        tg = par_mode ? anyq : mq[i];
        case (mph[i])
          0: if (tg != 0) begin mph[i] = 1; mrem[i] = TRP; end
          1: begin mrem[i]--; if (mrem[i] == 0) begin mph[i] = 2; mrem[i] = DIS; end end
          default: begin
            mrem[i]--;
            if (mrem[i] == 0) begin
              if (tg != 0) begin mph[i] = 1; mrem[i] = TRP; end
              else mph[i] = 0;
            end
          end
        endcase
        if (int'(oc_raw[i]) != mq[i]) begin
          if (mrun[i] + 1 >= (mq[i] != 0 ? OFF : ON)) begin
            mq[i] = int'(oc_raw[i]); mrun[i] = 0;
          end else mrun[i]++;
        end else mrun[i] = 0;
      end
      if (!mth && temp_val >= 10'(TT)) mth = 1'b1;
      else if (mth && temp_val <= 10'(TC)) mth = 1'b0;
      if (vs_vld) begin
        if (muv && vs_val > 10'(VON)) muv = 1'b0;
        else if (!muv && vs_val < 10'(VOFF)) muv = 1'b1;
      end
    end
  end

  function automatic logic [NB-1:0] exp_fault();
    logic [NB-1:0] r;
    for (int i = 0; i < NB; i++) r[i] = !((mq[i] != 0) || mth);
    return r;
  endfunction

  function automatic logic [NB-1:0] exp_dis();
    logic [NB-1:0] r;
    for (int i = 0; i < NB; i++) r[i] = (mph[i] == 2) || mth || muv;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en && !done) begin
      chk("R2 model fault_n", 32'(fault_n), 32'(exp_fault()));
      chk("R4 model br_dis", 32'(br_dis), 32'(exp_dis()));
      chk("R6 model therm", 32'(therm_active), 32'(mth));
      chk("R9 model uvlo", 32'(uvlo_active), 32'(muv));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    rst_n = 1'b0; oc_raw = '0; par_mode = 1'b0;
    temp_val = 10'd100; vs_val = 10'd0; vs_vld = 1'b0;
    step(2);
    // R1 reset state
    chk("R1 fault_n", 32'(fault_n), 32'h3);
    chk("R1 therm", 32'(therm_active), 32'h0);
    chk("R1 uvlo", 32'(uvlo_active), 32'h1);
    chk("R1 br_dis", 32'(br_dis), 32'h3);
    rst_n = 1'b1;
    mon_en = 1'b1;
    step(1);
    chk("R1 uvlo after release", 32'(uvlo_active), 32'h1);
    // R8 reading without strobe ignored
    vs_val = 10'd120;
    step(3);
    chk("R8 no strobe", 32'(uvlo_active), 32'h1);
    vs_vld = 1'b1;
    step(1);
    chk("R8 release", 32'(uvlo_active), 32'h0);
    chk("R8 dis low", 32'(br_dis), 32'h0);

    // R2 short glitch ignored
    oc_raw = 2'b01;
    step(2);
    oc_raw = 2'b00;
    step(3);
    chk("R2 glitch", 32'(fault_n), 32'h3);
    step(5);

    // R2/R3/R4/R11 single trip
    oc_raw = 2'b01;
    step(2);
    chk("R2 before delay", 32'(fault_n), 32'h3);
    step(1);
    chk("R2 asserted", 32'(fault_n), 32'h2);
    step(4);
    chk("R4 still on", 32'(br_dis), 32'h0);
    step(1);
    chk("R4 disabled", 32'(br_dis), 32'h1);
    oc_raw = 2'b00;
    step(1);
    chk("R3 release wait", 32'(fault_n), 32'h2);
    step(1);
    chk("R3 released", 32'(fault_n), 32'h3);
    step(17);
    chk("R4 hold end-1", 32'(br_dis), 32'h1);
    step(1);
    chk("R4 retry", 32'(br_dis), 32'h0);
    chk("R11 other bridge", 32'(br_dis[1]), 32'h0);
    step(5);

    // R5 recurrence
    oc_raw = 2'b01;
    step(8);
    chk("R5 first hold", 32'(br_dis), 32'h1);
    step(20);
    chk("R5 new delay", 32'(br_dis), 32'h0);
    chk("R5 fault kept", 32'(fault_n), 32'h2);
    step(4);
    chk("R5 new hold", 32'(br_dis), 32'h1);
    oc_raw = 2'b00;
    step(40);

    // R10 paralleled
    par_mode = 1'b1;
    oc_raw = 2'b10;
    step(8);
    chk("R10 both off", 32'(br_dis), 32'h3);
    chk("R10 fault only own", 32'(fault_n), 32'h1);
    oc_raw = 2'b00;
    step(40);
    par_mode = 1'b0;

    // R6/R7 thermal hysteresis
    temp_val = 10'd659;
    step(1);
    chk("R6 below", 32'(therm_active), 32'h0);
    temp_val = 10'd660;
    step(1);
    chk("R6 set", 32'(therm_active), 32'h1);
    chk("R6 faults", 32'(fault_n), 32'h0);
    chk("R6 dis", 32'(br_dis), 32'h3);
    temp_val = 10'd601;
    step(1);
    chk("R7 held", 32'(therm_active), 32'h1);
    temp_val = 10'd600;
    step(1);
    chk("R7 cleared", 32'(therm_active), 32'h0);

    // R8/R9 supply hysteresis
    vs_val = 10'd96;
    step(1);
    chk("R9 at level", 32'(uvlo_active), 32'h0);
    vs_val = 10'd95;
    step(1);
    chk("R9 set", 32'(uvlo_active), 32'h1);
    chk("R9 dis", 32'(br_dis), 32'h3);
    vs_vld = 1'b0; vs_val = 10'd200;
    step(3);
    chk("R8 ignored", 32'(uvlo_active), 32'h1);
    vs_vld = 1'b1; vs_val = 10'd112;
    step(1);
    chk("R8 at on level", 32'(uvlo_active), 32'h1);
    vs_val = 10'd113;
    step(1);
    chk("R8 above", 32'(uvlo_active), 32'h0);

    // random phase, model compared each cycle
    for (int c = 0; c < 6000; c++) begin
      for (int i = 0; i < NB; i++) if ($urandom_range(11) == 0) oc_raw[i] = ~oc_raw[i];
      if ($urandom_range(499) == 0) par_mode = ~par_mode;
      if ($urandom_range(7) == 0) temp_val = 10'($urandom_range(680, 585));
      vs_vld = 1'($urandom_range(1));
      if ($urandom_range(15) == 0) vs_val = 10'($urandom_range(118, 92));
      step(0);
    end
    step(2);
    finish_run();
  end
endmodule